// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a 4 KiB window of 32-bit system control registers on a simple register bus. The bus carries an address, separate read and write strobes, write data, and a read-data return. Software must first write a magic word to the key register at offset 0x000. Until it does, every write to any other offset is discarded. Reads are never blocked.

Behind the key sit several register kinds:
- Plain read/write storage.
- Control words that only gain bits through their own offset and only lose bits through a paired clear alias.
- Identity words that mirror a revision input.
- Two strap words whose direct write is refused while a companion protect word is nonzero.
- Three PLL extension words that always report lock.
- A data port that returns a new pseudo-random word on every read.

Strap values, the revision and the unlock state after reset come from input ports. All other storage resets to fixed constants. Read data is combinational from the presented address. Writes take effect at the clock edge on which the write strobe is sampled. A one-cycle error pulse follows any malformed access.

Top module: `sysctl_regbank`

## Requirements
- R1: Offset 0x000 is the key register. A write of 32'h1688A8A8 makes it read 32'h00000001. A write of any other value makes it read 0. It can be written whether the bank is locked or not. After reset it holds `unlock_at_reset`.
- R2: While the key reads 0, a write to any offset other than 0x000 changes no stored value.
- R3: A write to 0x040 ORs the data into that word. A write to 0x044 clears the bits of 0x040 where the data is 1. The pair 0x050/0x054 works the same way. Each clear alias reads back the value of its target.
- R4: A write to strap word 0x500 is stored only while protect word 0x508 reads zero. A write to 0x504 clears the bits of 0x500 where the data is 1, whatever the protect word holds. Offsets 0x510, 0x514 and 0x518 form the second strap group. Reset loads 0x500 from `strap1_init` and 0x510 from `strap2_init`.
- R5: Offsets 0x204, 0x224 and 0x244 store written data. They read back the stored value with bit 31 forced to 1.
- R6: Each read of 0x540 returns the current state of a 32-bit generator and then advances it. The next state is (s >> 1) XOR (s[0] ? 32'h80200003 : 0). Reset sets the state to 32'hACE12468. The contents of the random control word at 0x524 have no effect on this.
- R7: Offsets 0x004 and 0x014 both read `rev_id`. Writes to them, and to 0x540, store nothing.
- R8: After reset, 0x040 reads 32'hF7CFFFDC, 0x050 reads 32'hFFFFFFFC, 0x080 reads 32'hEFF43E8B, 0x090 reads 32'hFFF0FFF0, 0x100 reads 32'h00000040 and 0x200 reads 32'h1000405F. The PLL words, the protect words and 0x524 reset to 0. Offsets 0x080, 0x090, 0x100, 0x200, 0x508, 0x518 and 0x524 are plain read/write.
- R9: Any other word offset inside the 4 KiB window reads 0, ignores writes and raises no error.
- R10: The cycle after an access, `bus_err` is 1 in any of these cases: the address is at or above 0x1000, bits [1:0] of the address are nonzero, or the access is a write to 0x004, 0x014 or 0x540. Otherwise `bus_err` is 0. Out-of-window and misaligned accesses read 0, store nothing and do not advance the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address (combinational) |
| bus_err | output | 1 | One-cycle pulse after a malformed access |
| unlock_at_reset | input | 1 | Key state loaded at reset |
| rev_id | input | 32 | Revision value mirrored by both identity words |
| strap1_init | input | 32 | Reset value of the first strap word |
| strap2_init | input | 32 | Reset value of the second strap word |

## Verification
The bench builds the bank with its default 16-bit address, so the whole 4 KiB window is only 1024 word offsets. That makes complete sweeps affordable. Every offset is read after reset, written and read back while locked, and written and read back while unlocked, with the error flag checked on each access. Because the sweeps cover every offset in address order, the strap/protect interplay, the clear aliases, the unimplemented holes and the generator sequence all fall out of the same pass. Targeted accesses above the window and at misaligned addresses cover the error path.

// File: rtl/sysctl_pkg.sv
// Shared constants, register kinds and slot map for the system control bank.
// Assumes 32-bit data and a 4 KiB byte window.
package sysctl_pkg;
    localparam int          WORD_W     = 32;
    localparam int          REGION_LSB = 12;
    localparam logic [31:0] KEY_MAGIC  = 32'h1688A8A8;
    localparam logic [31:0] RNG_POLY   = 32'h80200003;
    localparam logic [31:0] RNG_SEED   = 32'hACE12468;

    typedef enum logic [3:0] {
        K_NONE, K_KEY, K_REV, K_RW, K_SET, K_CLR,
        K_STRAP, K_STRAP_CLR, K_PLL, K_RNG
    } kind_e;

    typedef enum logic [1:0] {OP_LOAD, OP_SET, OP_CLR} op_e;

    localparam int NSLOT  = 14;
    localparam int SLOT_W = $clog2(NSLOT);

    localparam int SL_RST1   = 0;
    localparam int SL_RST2   = 1;
    localparam int SL_CLK1   = 2;
    localparam int SL_CLK2   = 3;
    localparam int SL_DRAM   = 4;
    localparam int SL_HPLL   = 5;
    localparam int SL_HEXT   = 6;
    localparam int SL_MEXT   = 7;
    localparam int SL_EEXT   = 8;
    localparam int SL_STRAP1 = 9;
    localparam int SL_PROT1  = 10;
    localparam int SL_STRAP2 = 11;
    localparam int SL_PROT2  = 12;
    localparam int SL_RNGCTL = 13;

    // Fixed reset constant of each storage slot (strap slots are overridden).
    function automatic logic [WORD_W-1:0] slot_default(input int idx);
        case (idx)
            SL_RST1: return 32'hF7CFFFDC;
            SL_RST2: return 32'hFFFFFFFC;
            SL_CLK1: return 32'hEFF43E8B;
            SL_CLK2: return 32'hFFF0FFF0;
            SL_DRAM: return 32'h00000040;
            SL_HPLL: return 32'h1000405F;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_decode.sv
// Word-index decoder: maps a word index inside the window to a register kind,
// the storage slot it touches, and for strap words the slot of its protect word.
// Assumes the caller has already qualified range and alignment.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0]  widx,
    output kind_e             kind,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] prot_slot
);
    // Offset table lookup.
    always_comb begin
        kind      = K_NONE;
        slot      = '0;
        prot_slot = '0;
        case (widx)
            IDX_W'(10'h000): kind = K_KEY;
            IDX_W'(10'h001),
            IDX_W'(10'h005): kind = K_REV;
            IDX_W'(10'h010): begin kind = K_SET;       slot = SLOT_W'(SL_RST1);   end
            IDX_W'(10'h011): begin kind = K_CLR;       slot = SLOT_W'(SL_RST1);   end
            IDX_W'(10'h014): begin kind = K_SET;       slot = SLOT_W'(SL_RST2);   end
            IDX_W'(10'h015): begin kind = K_CLR;       slot = SLOT_W'(SL_RST2);   end
            IDX_W'(10'h020): begin kind = K_RW;        slot = SLOT_W'(SL_CLK1);   end
            IDX_W'(10'h024): begin kind = K_RW;        slot = SLOT_W'(SL_CLK2);   end
            IDX_W'(10'h040): begin kind = K_RW;        slot = SLOT_W'(SL_DRAM);   end
            IDX_W'(10'h080): begin kind = K_RW;        slot = SLOT_W'(SL_HPLL);   end
            IDX_W'(10'h081): begin kind = K_PLL;       slot = SLOT_W'(SL_HEXT);   end
            IDX_W'(10'h089): begin kind = K_PLL;       slot = SLOT_W'(SL_MEXT);   end
            IDX_W'(10'h091): begin kind = K_PLL;       slot = SLOT_W'(SL_EEXT);   end
            IDX_W'(10'h140): begin kind = K_STRAP;     slot = SLOT_W'(SL_STRAP1);
                                   prot_slot = SLOT_W'(SL_PROT1); end
            IDX_W'(10'h141): begin kind = K_STRAP_CLR; slot = SLOT_W'(SL_STRAP1); end
            IDX_W'(10'h142): begin kind = K_RW;        slot = SLOT_W'(SL_PROT1);  end
            IDX_W'(10'h144): begin kind = K_STRAP;     slot = SLOT_W'(SL_STRAP2);
                                   prot_slot = SLOT_W'(SL_PROT2); end
            IDX_W'(10'h145): begin kind = K_STRAP_CLR; slot = SLOT_W'(SL_STRAP2); end
            IDX_W'(10'h146): begin kind = K_RW;        slot = SLOT_W'(SL_PROT2);  end
            IDX_W'(10'h149): begin kind = K_RW;        slot = SLOT_W'(SL_RNGCTL); end
            IDX_W'(10'h150): kind = K_RNG;
            default: ;
        endcase
    end
endmodule

// File: rtl/sysctl_slot.sv
// One 32-bit storage word with load, OR-set and AND-NOT-clear updates.
// Assumes wr_en is already qualified by lock, range and protect state.
module sysctl_slot
    import sysctl_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         wr_en,
    input  op_e          op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold, or apply the selected update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= rst_val;
        end else if (wr_en) begin
            case (op)
                OP_SET:  q <= q | wdata;
                OP_CLR:  q <= q & ~wdata;
                default: q <= wdata;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_lfsr.sv
// Galois LFSR that advances one step per strobe.
// Assumes POLY describes a maximal-length polynomial and SEED is nonzero.
module sysctl_lfsr #(
    parameter int           W    = 32,
    parameter logic [W-1:0] POLY = 32'h80200003,
    parameter logic [W-1:0] SEED = 32'hACE12468
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] state
);
    // Shift right and fold in the polynomial when the output bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (step)
            state <= (state >> 1) ^ (state[0] ? POLY : '0);
    end
endmodule

// File: rtl/sysctl_regbank.sv
// Lockable system control register bank: key-gated writes, set/clear pairs,
// protect-gated straps, always-locked PLL words, identity mirrors and a
// fresh-per-read random port. Read data is combinational; writes, the
// generator step and the error pulse are registered.
// Assumes single-cycle read/write strobes and word-aligned accesses.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    input  logic              unlock_at_reset,
    input  logic [31:0]       rev_id,
    input  logic [31:0]       strap1_init,
    input  logic [31:0]       strap2_init
);
    localparam int IDX_W = REGION_LSB - 2;

    logic [IDX_W-1:0]              widx;
    logic                          in_window, aligned, valid;
    kind_e                         kind;
    logic [SLOT_W-1:0]             slot, prot_slot;
    logic [NSLOT-1:0][WORD_W-1:0]  slot_q;
    logic [WORD_W-1:0]             sel_val, prot_val, lfsr_state;
    logic                          key_q, err_q;
    logic                          writable, strap_held, slot_wr_ok, ro_write;
    op_e                           op;

    assign widx      = bus_addr[REGION_LSB-1:2];
    assign in_window = (bus_addr[ADDR_W-1:REGION_LSB] == '0);
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign valid     = in_window && aligned;

    sysctl_decode #(.IDX_W(IDX_W)) u_dec (
        .widx(widx), .kind(kind), .slot(slot), .prot_slot(prot_slot)
    );

    // Pick the addressed slot and the strap's protect slot.
    always_comb begin
        sel_val  = '0;
        prot_val = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot == SLOT_W'(i))      sel_val  = slot_q[i];
            if (prot_slot == SLOT_W'(i)) prot_val = slot_q[i];
        end
    end

    // Classify the write: which kinds store, and how.
    always_comb begin
        writable = 1'b0;
        op       = OP_LOAD;
        case (kind)
            K_RW, K_PLL, K_STRAP: writable = 1'b1;
            K_SET:                begin writable = 1'b1; op = OP_SET; end
            K_CLR, K_STRAP_CLR:   begin writable = 1'b1; op = OP_CLR; end
            default: ;
        endcase
    end

    assign strap_held = (kind == K_STRAP) && (prot_val != '0);
    assign slot_wr_ok = bus_wr && valid && key_q && writable && !strap_held;
    assign ro_write   = bus_wr && valid && (kind == K_REV || kind == K_RNG);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [WORD_W-1:0] rv;
        if (g == SL_STRAP1) begin : g_s1
            assign rv = strap1_init;
        end else if (g == SL_STRAP2) begin : g_s2
            assign rv = strap2_init;
        end else begin : g_fix
            assign rv = slot_default(g);
        end
        sysctl_slot #(.W(WORD_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .rst_val(rv),
            .wr_en(slot_wr_ok && (slot == SLOT_W'(g))),
            .op(op), .wdata(bus_wdata), .q(slot_q[g])
        );
    end

    sysctl_lfsr #(.W(WORD_W), .POLY(RNG_POLY), .SEED(RNG_SEED)) u_rng (
        .clk(clk), .rst_n(rst_n),
        .step(bus_rd && valid && (kind == K_RNG)),
        .state(lfsr_state)
    );

    // Key register: magic value unlocks, anything else locks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_q <= unlock_at_reset;
        else if (bus_wr && valid && kind == K_KEY)
            key_q <= (bus_wdata == KEY_MAGIC);
    end

    // Error pulse for malformed accesses and read-only writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= ((bus_rd || bus_wr) && !valid) || ro_write;
    end

    // Read data for the presented address.
    always_comb begin
        bus_rdata = '0;
        if (valid) begin
            case (kind)
                K_KEY:                    bus_rdata = {31'b0, key_q};
                K_REV:                    bus_rdata = rev_id;
                K_RW, K_SET, K_CLR,
                K_STRAP, K_STRAP_CLR:     bus_rdata = sel_val;
                K_PLL:                    bus_rdata = sel_val | 32'h80000000;
                K_RNG:                    bus_rdata = lfsr_state;
                default:                  bus_rdata = '0;
            endcase
        end
    end

    assign bus_err = err_q;
endmodule

// File: rtl/sysctl_regbank_chk.sv
// Property checker for sysctl_regbank, attached by bind.
// Assumes the top's internal key_q, slot_q and lfsr_state names.
module sysctl_regbank_chk
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [31:0]                  bus_wdata,
    input logic [31:0]                  bus_rdata,
    input logic                         bus_err,
    input logic [31:0]                  rev_id,
    input logic                         key_q,
    input logic [NSLOT-1:0][WORD_W-1:0] slot_q,
    input logic [WORD_W-1:0]            lfsr_state
);
    AST_KEY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata[31:1] == '0)); // R1

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_q && bus_wr && bus_addr != '0) |=> $stable(slot_q)); // R2

    AST_SET_ONLY_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_q && bus_wr && bus_addr == ADDR_W'(16'h0040)) |=>
        ((($past(slot_q[SL_RST1]) & ~slot_q[SL_RST1]) == '0) &&
         ((slot_q[SL_RST1] & $past(bus_wdata)) == $past(bus_wdata)))); // R3

    AST_PLL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(16'h0204) || bus_addr == ADDR_W'(16'h0224) ||
         bus_addr == ADDR_W'(16'h0244)) |-> bus_rdata[31]); // R5

    AST_RNG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(16'h0540)) |=>
        (lfsr_state != $past(lfsr_state))); // R6

    AST_REV_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(16'h0004) || bus_addr == ADDR_W'(16'h0014)) |->
        (bus_rdata == rev_id)); // R7

    AST_ERR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[ADDR_W-1:REGION_LSB] != '0) |=> bus_err); // R10
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .rev_id(rev_id), .key_q(key_q), .slot_q(slot_q),
    .lfsr_state(lfsr_state)
);

// File: tb/tb_sysctl_regbank.sv
// Sweep bench for sysctl_regbank: every word offset of the window is read
// and written against an arithmetic model kept in the bench.
module tb_sysctl_regbank;
    localparam int          ADDR_W = 16;
    localparam logic [31:0] MAGIC  = 32'h1688A8A8;
    localparam logic [31:0] POLY   = 32'h80200003;
    localparam logic [31:0] SEED   = 32'hACE12468;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_err;
    logic              unlock_at_reset = 1'b0;
    logic [31:0]       rev_id = 32'h05030303;
    logic [31:0]       strap1_init = 32'h0000A5F0;
    logic [31:0]       strap2_init = 32'h12340001;

    int checks = 0, fails = 0;
    logic [31:0] m_val [0:1023];
    logic        m_key;
    logic [31:0] m_rng;

    always #2 clk = ~clk;

    sysctl_regbank #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .unlock_at_reset(unlock_at_reset), .rev_id(rev_id),
        .strap1_init(strap1_init), .strap2_init(strap2_init)
    );

    // Bench register map: 0 none,1 key,2 rev,3 rw,4 set,5 clr,6 strap,7 strap-clear,8 pll,9 rng
    function automatic int b_kind(int w);
        case (w)
            0: return 1;
            1, 5: return 2;
            'h20, 'h24, 'h40, 'h80, 'h142, 'h146, 'h149: return 3;
            'h10, 'h14: return 4;
            'h11, 'h15: return 5;
            'h140, 'h144: return 6;
            'h141, 'h145: return 7;
            'h81, 'h89, 'h91: return 8;
            'h150: return 9;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int k);
        case (k)
            1: return "R1";
            2: return "R7";
            4, 5: return "R3";
            6, 7: return "R4";
            8: return "R5";
            9: return "R6";
            0: return "R9";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] rng_next(logic [31:0] s);
        return (s >> 1) ^ (s[0] ? POLY : 32'h0);
    endfunction

    function automatic logic [31:0] exp_rd(int w);
        case (b_kind(w))
            1: return {31'b0, m_key};
            2: return rev_id;
            5, 7: return m_val[w-1];
            8: return m_val[w] | 32'h80000000;
            0: return 32'h0;
            default: return m_val[w];
        endcase
    endfunction

    task automatic b_apply(int w, logic [31:0] d);
        int k = b_kind(w);
        if (k == 1) begin m_key = (d == MAGIC); return; end
        if (!m_key) return;
        case (k)
            3, 8: m_val[w] = d;
            4:    m_val[w] = m_val[w] | d;
            5, 7: m_val[w-1] = m_val[w-1] & ~d;
            6:    if (m_val[w+2] == 0) m_val[w] = d;
            default: ;
        endcase
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(logic [ADDR_W-1:0] a, logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        e = bus_err;
    endtask

    task automatic do_rd(logic [ADDR_W-1:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        e = bus_err;
    endtask

    task automatic do_reset(logic unl, logic [31:0] s1, logic [31:0] s2);
        @(negedge clk);
        rst_n = 1'b0; unlock_at_reset = unl; strap1_init = s1; strap2_init = s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) m_val[i] = 32'h0;
        m_val['h10] = 32'hF7CFFFDC; m_val['h14] = 32'hFFFFFFFC;
        m_val['h20] = 32'hEFF43E8B; m_val['h24] = 32'hFFF0FFF0;
        m_val['h40] = 32'h00000040; m_val['h80] = 32'h1000405F;
        m_val['h140] = s1; m_val['h144] = s2;
        m_key = unl; m_rng = SEED;
    endtask

    // Read a word offset and compare with the model (R6 generator included).
    task automatic chk_rd(int w, string tag);
        logic [31:0] got, exp; logic e;
        int k = b_kind(w);
        if (k == 9) begin exp = m_rng; m_rng = rng_next(m_rng); end
        else exp = exp_rd(w);
        do_rd(ADDR_W'(w << 2), got, e);
        check(got == exp, req_of(k), $sformatf("%s read off %h", tag, w << 2), got, exp);
        check(e == 1'b0, "R10", $sformatf("%s read err off %h", tag, w << 2), 32'(e), 32'h0);
    endtask

    task automatic sweep_read(string tag);
        for (int w = 0; w < 1024; w++) chk_rd(w, tag);
    endtask

    // Write every offset except the key, checking the error flag (R10, R7).
    task automatic sweep_write(logic [31:0] base, string tag);
        logic e;
        for (int w = 1; w < 1024; w++) begin
            logic [31:0] d = base ^ (32'(w) * 32'h9E3779B1);
            int k = b_kind(w);
            do_wr(ADDR_W'(w << 2), d, e);
            b_apply(w, d);
            check(e == (k == 2 || k == 9), "R10", $sformatf("%s write err off %h", tag, w << 2),
                  32'(e), 32'(k == 2 || k == 9));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] got; logic e;
        do_reset(1'b0, 32'h0000A5F0, 32'h12340001);
        // R8 R4 R7 R1: reset image across the whole window
        sweep_read("reset");
        // R2: locked writes are dropped everywhere
        sweep_write(32'h3C3C5A5A, "locked");
        sweep_read("after-locked");
        // R1: wrong key stays locked, magic unlocks
        do_wr(16'h0000, 32'h1688A8A9, e); b_apply(0, 32'h1688A8A9);
        do_rd(16'h0000, got, e);
        check(got == 32'h0, "R1", "wrong key", got, 32'h0);
        do_wr(16'h0000, MAGIC, e); b_apply(0, MAGIC);
        do_rd(16'h0000, got, e);
        check(got == 32'h1, "R1", "magic key", got, 32'h1);
        // R3 R4 R5 R8 R9: unlocked sweep then readback
        sweep_write(32'hC0FFEE11, "unlocked");
        sweep_read("after-unlocked");
        // R3: explicit set/clear sequence
        do_wr(16'h0044, 32'hFFFFFFFF, e); b_apply('h11, 32'hFFFFFFFF);
        do_wr(16'h0040, 32'h00000081, e); b_apply('h10, 32'h00000081);
        do_wr(16'h0040, 32'h00000100, e); b_apply('h10, 32'h00000100);
        do_wr(16'h0044, 32'h00000001, e); b_apply('h11, 32'h00000001);
        do_rd(16'h0040, got, e);
        check(got == 32'h00000180, "R3", "set/clear result", got, 32'h00000180);
        do_rd(16'h0044, got, e);
        check(got == 32'h00000180, "R3", "clear alias readback", got, 32'h00000180);
        // R4: protect blocks the direct write only
        do_wr(16'h0508, 32'h5, e); b_apply('h142, 32'h5);
        do_wr(16'h0500, 32'hFFFF0000, e); b_apply('h140, 32'hFFFF0000);
        chk_rd('h140, "strap protected");
        do_wr(16'h0504, 32'hFFFFFFFF, e); b_apply('h141, 32'hFFFFFFFF);
        do_rd(16'h0500, got, e);
        check(got == 32'h0, "R4", "strap clear under protect", got, 32'h0);
        do_wr(16'h0508, 32'h0, e); b_apply('h142, 32'h0);
        do_wr(16'h0500, 32'hFFFF0000, e); b_apply('h140, 32'hFFFF0000);
        do_wr(16'h0504, 32'h0F0F0000, e); b_apply('h141, 32'h0F0F0000);
        do_rd(16'h0500, got, e);
        check(got == 32'hF0F00000, "R4", "strap write then clear", got, 32'hF0F00000);
        // R6: random control cleared, port still advances
        do_wr(16'h0524, 32'h0, e); b_apply('h149, 32'h0);
        chk_rd('h150, "rng ctl off a");
        chk_rd('h150, "rng ctl off b");
        // R10: out-of-window and misaligned accesses
        do_rd(16'h1000, got, e);
        check(got == 32'h0, "R10", "oob read data", got, 32'h0);
        check(e == 1'b1, "R10", "oob read err", 32'(e), 32'h1);
        do_wr(16'h2080, 32'h12345678, e);
        check(e == 1'b1, "R10", "oob write err", 32'(e), 32'h1);
        do_wr(16'h0082, 32'h12345678, e);
        check(e == 1'b1, "R10", "misaligned write err", 32'(e), 32'h1);
        chk_rd('h20, "after misaligned write");
        do_rd(16'h0541, got, e);
        check(got == 32'h0 && e == 1'b1, "R10", "misaligned rng read", got, 32'h0);
        chk_rd('h150, "rng after misaligned");
        // R1 R2: relock then a write is dropped
        do_wr(16'h0000, 32'h0, e); b_apply(0, 32'h0);
        do_wr(16'h0080, 32'hDEADBEEF, e); b_apply('h20, 32'hDEADBEEF);
        chk_rd('h20, "relocked write");
        // R1 R4 R6 R8: reset with unlock input high and new straps
        do_reset(1'b1, 32'hFFFF0000, 32'h0000FFFF);
        sweep_read("reset2");
        do_wr(16'h0090, 32'h01020304, e); b_apply('h24, 32'h01020304);
        chk_rd('h24, "unlocked from reset");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule